// File: doc/BRIEF.md
# Privileged-Mode Trap and Entry Vector Unit

This unit decides when and where a CPU enters its privileged supervisor mode. It watches the CPU address bus for accesses into a 64-slot register window. An unprivileged access to any slot becomes a trap. The slot number, scaled by four, is added to a vector base to give the entry address. A hardware reset uses its own entry address, one past the last trap slot, so supervisor code can tell a reset apart from a trap.

On a trap the unit copies the CPU register set (program counter, accumulator, three index registers, stack pointer, status byte and a 16-bit memory-map word) into a save bank in the same cycle. While privileged, the same window becomes a register file over that bank, so the supervisor can inspect and edit the saved state. Writing the last slot leaves privileged mode and presents the saved state for the CPU to reload.

Both outgoing events use valid/ready handshakes:
- The entry vector (address plus a reset marker) stays valid and unchanged until the CPU accepts it.
- The restored register set does the same.
- While either event is waiting, every bus strobe is ignored.

A separate sticky "upgraded" flag can be set once by privileged software. A CPU reset does not clear it; only power-on reset does.

Top module: `hv_trap_gen`

## Requirements
- R1: While reset is applied and after it is released, `priv_mode` is 1, and the vector port offers `vec_pc` = 0x8100 with `vec_is_reset` = 1 and `vec_valid` = 1 until it is accepted.
- R2: With `priv_mode` = 0 and no event waiting, a strobe (read or write) to any address 0xD640..0xD67F makes the next cycle show `vec_valid` = 1, `vec_is_reset` = 0, `priv_mode` = 1 and `vec_pc` = 0x8000 + 4 × addr[5:0].
- R3: With `priv_mode` = 0, strobes outside 0xD640..0xD67F cause no vector and leave `priv_mode` at 0.
- R4: A trap captures the CPU register inputs from the trap cycle. In privileged mode `bus_rdata` combinationally returns them by window offset: 0x00 A, 0x01 X, 0x02 Y, 0x03 Z, 0x04 SP[7:0], 0x05 SP[15:8], 0x06 P, 0x08 PC[7:0], 0x09 PC[15:8], 0x0A MAP[7:0], 0x0B MAP[15:8]. Other offsets below 0x3E read 0.
- R5: A privileged write to one of the R4 offsets replaces that byte of the saved state, and causes neither a trap nor an exit.
- R6: A privileged write to offset 0x3F (address 0xD67F) sets `priv_mode` to 0 in the next cycle and raises `ret_valid`, with `ret_*` carrying the saved state including any R5 edits.
- R7: While `vec_valid` or `ret_valid` is high and its ready is low, the valid stays high and its payload stays unchanged.
- R8: While `vec_valid` or `ret_valid` is high, bus strobes have no effect: no trap, no exit and no mode change.
- R9: The upgraded flag resets to 0 at power-on. A privileged write to offset 0x3E with data bit 0 = 1 sets it. The flag appears on `upgraded` and at bit 0 of `bus_rdata` for offset 0x3E.
- R10: Once set, the upgraded flag ignores further writes, including a write of 0. It survives `rst_n` and clears only on `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything including the upgraded flag |
| rst_n | input | 1 | CPU reset, active low, synchronous; leaves the upgraded flag alone |
| bus_addr | input | 16 | CPU address |
| bus_strobe | input | 1 | Access strobe, one per access |
| bus_we | input | 1 | 1 = write access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Window read data in privileged mode, 0 otherwise |
| cpu_pc | input | 16 | Live program counter to save |
| cpu_sp | input | 16 | Live stack pointer to save |
| cpu_map | input | 16 | Live memory-map word to save |
| cpu_a | input | 8 | Live accumulator |
| cpu_x | input | 8 | Live X register |
| cpu_y | input | 8 | Live Y register |
| cpu_z | input | 8 | Live Z register |
| cpu_p | input | 8 | Live status byte |
| priv_mode | output | 1 | 1 = privileged mode |
| upgraded | output | 1 | Sticky upgraded flag |
| vec_valid | output | 1 | Entry vector offered |
| vec_ready | input | 1 | CPU accepts the entry vector |
| vec_pc | output | 16 | Entry address |
| vec_is_reset | output | 1 | 1 = the entry is the reset entry |
| ret_valid | output | 1 | Restored state offered |
| ret_ready | input | 1 | CPU accepts the restored state |
| ret_pc | output | 16 | Restored program counter |
| ret_sp | output | 16 | Restored stack pointer |
| ret_map | output | 16 | Restored memory-map word |
| ret_a | output | 8 | Restored accumulator |
| ret_x | output | 8 | Restored X |
| ret_y | output | 8 | Restored Y |
| ret_z | output | 8 | Restored Z |
| ret_p | output | 8 | Restored status byte |

## Verification
Every cycle, the assertions check:
- that an unprivileged window strobe yields the scaled entry address one cycle later;
- that out-of-window strobes change nothing;
- that the exit slot drops privilege and raises the restore handshake;
- that waiting payloads hold still under back-pressure;
- that the reset entry always carries 0x8100;
- that the upgraded flag never falls except at power-on.

Only the bench scenarios can show the other behaviours: that the snapshot holds the register values of the trap cycle rather than later ones, that supervisor edits come back in the restored set, that strobes during a waiting handshake are truly lost, and that the flag survives a CPU reset but not a power-on.

// File: rtl/hv_pkg.sv
package hv_pkg;

  localparam int HV_DW = 8;
  localparam int HV_WW = 16;

  typedef struct packed {
    logic [HV_WW-1:0] pc;
    logic [HV_WW-1:0] sp;
    logic [HV_WW-1:0] mmap;
    logic [HV_DW-1:0] a;
    logic [HV_DW-1:0] x;
    logic [HV_DW-1:0] y;
    logic [HV_DW-1:0] z;
    logic [HV_DW-1:0] p;
  } hv_cpu_t;

  // window offsets of the saved-state bytes
  localparam int OFS_A   = 0;
  localparam int OFS_X   = 1;
  localparam int OFS_Y   = 2;
  localparam int OFS_Z   = 3;
  localparam int OFS_SPL = 4;
  localparam int OFS_SPH = 5;
  localparam int OFS_P   = 6;
  localparam int OFS_PCL = 8;
  localparam int OFS_PCH = 9;
  localparam int OFS_MPL = 10;
  localparam int OFS_MPH = 11;

endpackage

// File: rtl/hv_win_decode.sv
module hv_win_decode #(
  parameter int ADDR_W = 16,
  parameter int SLOT_BITS = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD640
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [SLOT_BITS-1:0] slot
);
  assign hit  = (addr[ADDR_W-1:SLOT_BITS] == WIN_BASE[ADDR_W-1:SLOT_BITS]);
  assign slot = addr[SLOT_BITS-1:0];
endmodule

// File: rtl/hv_save_bank.sv
module hv_save_bank
  import hv_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_en,
  input  hv_cpu_t          snap_in,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [HV_DW-1:0] wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [HV_DW-1:0] rd_data,
  output hv_cpu_t          state
);
  hv_cpu_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (snap_en) begin
      st_q <= snap_in;
    end else if (wr_en) begin
      case (wr_ofs)
        OFS_W'(OFS_A):   st_q.a <= wr_data;
        OFS_W'(OFS_X):   st_q.x <= wr_data;
        OFS_W'(OFS_Y):   st_q.y <= wr_data;
        OFS_W'(OFS_Z):   st_q.z <= wr_data;
        OFS_W'(OFS_SPL): st_q.sp[7:0] <= wr_data;
        OFS_W'(OFS_SPH): st_q.sp[15:8] <= wr_data;
        OFS_W'(OFS_P):   st_q.p <= wr_data;
        OFS_W'(OFS_PCL): st_q.pc[7:0] <= wr_data;
        OFS_W'(OFS_PCH): st_q.pc[15:8] <= wr_data;
        OFS_W'(OFS_MPL): st_q.mmap[7:0] <= wr_data;
        OFS_W'(OFS_MPH): st_q.mmap[15:8] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_ofs)
      OFS_W'(OFS_A):   rd_data = st_q.a;
      OFS_W'(OFS_X):   rd_data = st_q.x;
      OFS_W'(OFS_Y):   rd_data = st_q.y;
      OFS_W'(OFS_Z):   rd_data = st_q.z;
      OFS_W'(OFS_SPL): rd_data = st_q.sp[7:0];
      OFS_W'(OFS_SPH): rd_data = st_q.sp[15:8];
      OFS_W'(OFS_P):   rd_data = st_q.p;
      OFS_W'(OFS_PCL): rd_data = st_q.pc[7:0];
      OFS_W'(OFS_PCH): rd_data = st_q.pc[15:8];
      OFS_W'(OFS_MPL): rd_data = st_q.mmap[7:0];
      OFS_W'(OFS_MPH): rd_data = st_q.mmap[15:8];
      default:         rd_data = '0;
    endcase
  end

  assign state = st_q;
endmodule

// File: rtl/hv_sticky_flag.sv
module hv_sticky_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!por_n)       flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
  end
endmodule

// File: rtl/hv_trap_gen.sv
module hv_trap_gen
  import hv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_BITS = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD640,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h8000,
  parameter int VEC_SHIFT = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_strobe,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [15:0]       cpu_pc,
  input  logic [15:0]       cpu_sp,
  input  logic [15:0]       cpu_map,
  input  logic [7:0]        cpu_a,
  input  logic [7:0]        cpu_x,
  input  logic [7:0]        cpu_y,
  input  logic [7:0]        cpu_z,
  input  logic [7:0]        cpu_p,
  output logic              priv_mode,
  output logic              upgraded,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [ADDR_W-1:0] vec_pc,
  output logic              vec_is_reset,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [15:0]       ret_pc,
  output logic [15:0]       ret_sp,
  output logic [15:0]       ret_map,
  output logic [7:0]        ret_a,
  output logic [7:0]        ret_x,
  output logic [7:0]        ret_y,
  output logic [7:0]        ret_z,
  output logic [7:0]        ret_p
);
  localparam int SLOTS = 1 << SLOT_BITS;
  localparam logic [ADDR_W-1:0] RESET_PC = ADDR_W'(VEC_BASE + (SLOTS << VEC_SHIFT));
  localparam logic [SLOT_BITS-1:0] EXIT_SLOT = SLOT_BITS'(SLOTS - 1);
  localparam logic [SLOT_BITS-1:0] UPG_SLOT  = SLOT_BITS'(SLOTS - 2);

  logic                 cpu_rst_n;
  logic                 win_hit;
  logic [SLOT_BITS-1:0] win_slot;
  logic                 waiting, take, trap_go, priv_wr, exit_go, upg_set;
  logic [HV_DW-1:0]     bank_rd;
  hv_cpu_t              live, saved;
  logic                 priv_q, vec_v_q, vec_rst_q, ret_v_q;
  logic [ADDR_W-1:0]    vec_pc_q;

  assign cpu_rst_n = rst_n & por_n;

  hv_win_decode #(
    .ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr(bus_addr), .hit(win_hit), .slot(win_slot)
  );

  assign waiting = vec_v_q | ret_v_q;
  assign take    = bus_strobe & ~waiting;
  assign trap_go = take & ~priv_q & win_hit;
  assign priv_wr = take & priv_q & win_hit & bus_we;
  assign exit_go = priv_wr & (win_slot == EXIT_SLOT);
  assign upg_set = priv_wr & (win_slot == UPG_SLOT) & bus_wdata[0];

  assign live = '{pc: cpu_pc, sp: cpu_sp, mmap: cpu_map,
                  a: cpu_a, x: cpu_x, y: cpu_y, z: cpu_z, p: cpu_p};

  hv_save_bank #(.OFS_W(SLOT_BITS)) u_bank (
    .clk(clk), .rst_n(cpu_rst_n),
    .snap_en(trap_go), .snap_in(live),
    .wr_en(priv_wr), .wr_ofs(win_slot), .wr_data(bus_wdata),
    .rd_ofs(win_slot), .rd_data(bank_rd),
    .state(saved)
  );

  hv_sticky_flag u_upg (
    .clk(clk), .por_n(por_n), .set_req(upg_set), .flag(upgraded)
  );

  always_ff @(posedge clk) begin
    if (!cpu_rst_n) begin
      priv_q    <= 1'b1;
      vec_v_q   <= 1'b1;
      vec_pc_q  <= RESET_PC;
      vec_rst_q <= 1'b1;
      ret_v_q   <= 1'b0;
    end else begin
      if (vec_v_q && vec_ready) vec_v_q <= 1'b0;
      if (ret_v_q && ret_ready) ret_v_q <= 1'b0;
      if (trap_go) begin
        vec_v_q   <= 1'b1;
        vec_pc_q  <= VEC_BASE + (ADDR_W'(win_slot) << VEC_SHIFT);
        vec_rst_q <= 1'b0;
        priv_q    <= 1'b1;
      end
      if (exit_go) begin
        priv_q  <= 1'b0;
        ret_v_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (priv_q && win_hit) begin
      if (win_slot == UPG_SLOT) bus_rdata = {7'b0, upgraded};
      else                      bus_rdata = bank_rd;
    end
  end

  assign priv_mode    = priv_q;
  assign vec_valid    = vec_v_q;
  assign vec_pc       = vec_pc_q;
  assign vec_is_reset = vec_rst_q;
  assign ret_valid    = ret_v_q;
  assign ret_pc  = saved.pc;
  assign ret_sp  = saved.sp;
  assign ret_map = saved.mmap;
  assign ret_a   = saved.a;
  assign ret_x   = saved.x;
  assign ret_y   = saved.y;
  assign ret_z   = saved.z;
  assign ret_p   = saved.p;
endmodule

// File: rtl/hv_trap_gen_chk.sv
module hv_trap_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int SLOT_BITS = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD640,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h8000,
  parameter int VEC_SHIFT = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_strobe,
  input logic              bus_we,
  input logic              priv_mode,
  input logic              upgraded,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [ADDR_W-1:0] vec_pc,
  input logic              vec_is_reset,
  input logic              ret_valid,
  input logic              ret_ready,
  input logic [87:0]       ret_bus
);
  localparam logic [ADDR_W-1:0] RST_ENTRY =
    ADDR_W'(VEC_BASE + ((1 << SLOT_BITS) << VEC_SHIFT));

  logic in_win, at_exit, idle;
  assign in_win  = (bus_addr[ADDR_W-1:SLOT_BITS] == WIN_BASE[ADDR_W-1:SLOT_BITS]);
  assign at_exit = in_win && (&bus_addr[SLOT_BITS-1:0]);
  assign idle    = !vec_valid && !ret_valid;

  AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    vec_valid && vec_is_reset |-> vec_pc == RST_ENTRY && priv_mode); // R1

  AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !priv_mode && bus_strobe && in_win && idle |=>
      vec_valid && !vec_is_reset && priv_mode &&
      vec_pc == ADDR_W'(VEC_BASE + (ADDR_W'($past(bus_addr[SLOT_BITS-1:0])) << VEC_SHIFT))); // R2

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !priv_mode && bus_strobe && !in_win && idle |=> !vec_valid && !priv_mode); // R3

  AST_EXIT_RETURN: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    priv_mode && bus_strobe && bus_we && at_exit && idle |=> !priv_mode && ret_valid); // R6

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_pc) && $stable(vec_is_reset)); // R7

  AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ret_valid && !ret_ready |=> ret_valid && $stable(ret_bus)); // R7

  AST_WAIT_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (vec_valid && !vec_ready) || (ret_valid && !ret_ready) |=> $stable(priv_mode)); // R8

  AST_UPG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    upgraded |=> upgraded); // R10
endmodule

bind hv_trap_gen hv_trap_gen_chk #(
  .ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS), .WIN_BASE(WIN_BASE),
  .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n),
  .bus_addr(bus_addr), .bus_strobe(bus_strobe), .bus_we(bus_we),
  .priv_mode(priv_mode), .upgraded(upgraded),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_pc(vec_pc),
  .vec_is_reset(vec_is_reset),
  .ret_valid(ret_valid), .ret_ready(ret_ready),
  .ret_bus({ret_pc, ret_sp, ret_map, ret_a, ret_x, ret_y, ret_z, ret_p})
);

// File: tb/hv_trap_gen_bench.sv
module hv_trap_gen_bench;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_strobe = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [15:0] cpu_pc = '0, cpu_sp = '0, cpu_map = '0;
  logic [7:0] cpu_a = '0, cpu_x = '0, cpu_y = '0, cpu_z = '0, cpu_p = '0;
  logic priv_mode, upgraded, vec_valid, vec_is_reset, ret_valid;
  logic vec_ready = 1'b1, ret_ready = 1'b1;
  logic [15:0] vec_pc, ret_pc, ret_sp, ret_map;
  logic [7:0] ret_a, ret_x, ret_y, ret_z, ret_p;

  int n_cmp = 0, n_bad = 0;
  logic [16:0] exp_vec[$];
  logic [87:0] exp_ret[$];

  always #2 clk = ~clk;

  hv_trap_gen u_hv_trap_gen (.*);

  task automatic check(input string req, input logic [87:0] act, input logic [87:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expected items on each accepted handshake
  always begin
    @(negedge clk); #1;
    if (rst_n && por_n) begin
      if (vec_valid && vec_ready) begin
        if (exp_vec.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2: actual vector %h expected none", vec_pc);
        end else check("R2 vector", 88'({vec_is_reset, vec_pc}), 88'(exp_vec.pop_front()));
      end
      if (ret_valid && ret_ready) begin
        if (exp_ret.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R6: actual return %h expected none", ret_pc);
        end else check("R6 restore",
          {ret_pc, ret_sp, ret_map, ret_a, ret_x, ret_y, ret_z, ret_p}, exp_ret.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1: actual hung expected completion (watchdog)");
    summary();
    $finish;
  end

  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d; bus_strobe = 1'b1;
    @(negedge clk);
    bus_strobe = 1'b0; bus_we = 1'b0;
    #1;
  endtask

  task automatic trap(input logic [15:0] a, input logic we);
    exp_vec.push_back({1'b0, 16'h8000 + {a[5:0], 2'b00}});
    access(a, we, 8'h77);
  endtask

  task automatic rd(input logic [5:0] ofs, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 16'hD640 | 16'(ofs);
    #1 d = bus_rdata;
  endtask

  task automatic set_cpu(input logic [87:0] v);
    {cpu_pc, cpu_sp, cpu_map, cpu_a, cpu_x, cpu_y, cpu_z, cpu_p} = v;
  endtask

  logic [7:0] rv;
  localparam logic [87:0] SET_A = {16'h1234, 16'h01FD, 16'hB300, 8'h11, 8'h22, 8'h33, 8'h44, 8'hA5};
  localparam logic [87:0] SET_B = {16'hF0C1, 16'h01FB, 16'hE300, 8'h9A, 8'hBC, 8'hDE, 8'h0F, 8'h65};

  initial begin
    exp_vec.push_back({1'b1, 16'h8100});
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    #1;
    check("R1 reset priv", 88'(priv_mode), 88'd1);
    check("R1 reset vector", 88'({vec_valid, vec_is_reset, vec_pc}), 88'({2'b11, 16'h8100}));
    check("R9 flag clear at power-on", 88'(upgraded), 88'd0);

    // leave privileged mode after reset: restores the cleared bank
    exp_ret.push_back('0);
    access(16'hD67F, 1'b1, 8'h00);
    check("R6 exit drops priv", 88'(priv_mode), 88'd0);

    // out-of-window accesses, including both window neighbours
    access(16'hD000, 1'b1, 8'h12);
    access(16'hD63F, 1'b0, 8'h00);
    access(16'hD680, 1'b1, 8'h34);
    check("R3 outside window", 88'({priv_mode, vec_valid}), 88'd0);

    // trap on slot 0 and inspect the snapshot
    set_cpu(SET_A);
    trap(16'hD640, 1'b0);
    check("R2 trap enters priv", 88'(priv_mode), 88'd1);
    set_cpu(SET_B);
    rd(6'h00, rv); check("R4 saved A", 88'(rv), 88'h11);
    rd(6'h01, rv); check("R4 saved X", 88'(rv), 88'h22);
    rd(6'h03, rv); check("R4 saved Z", 88'(rv), 88'h44);
    rd(6'h05, rv); check("R4 saved SP hi", 88'(rv), 88'h01);
    rd(6'h06, rv); check("R4 saved P", 88'(rv), 88'hA5);
    rd(6'h08, rv); check("R4 saved PC lo", 88'(rv), 88'h34);
    rd(6'h0B, rv); check("R4 saved MAP hi", 88'(rv), 88'hB3);
    rd(6'h07, rv); check("R4 unused offset", 88'(rv), 88'h00);

    // supervisor edits
    access(16'hD640, 1'b1, 8'h5A);
    access(16'hD649, 1'b1, 8'h40);
    rd(6'h00, rv); check("R5 edited A", 88'(rv), 88'h5A);
    check("R5 no exit on edit", 88'({priv_mode, ret_valid, vec_valid}), 88'({3'b100}));
    exp_ret.push_back({16'h4034, 16'h01FD, 16'hB300, 8'h5A, 8'h22, 8'h33, 8'h44, 8'hA5});
    access(16'hD67F, 1'b1, 8'h00);

    // unprivileged read of the last slot traps (does not exit)
    trap(16'hD67F, 1'b0);
    check("R2 slot 63 priv", 88'(priv_mode), 88'd1);
    exp_ret.push_back(SET_B);
    access(16'hD67F, 1'b1, 8'h00);

    // vector back-pressure
    @(negedge clk); vec_ready = 1'b0;
    trap(16'hD655, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R7 vector held", 88'({vec_valid, vec_pc}), 88'({1'b1, 16'h8054}));
    end
    access(16'hD67F, 1'b1, 8'h00);
    check("R8 exit ignored while waiting", 88'({priv_mode, ret_valid}), 88'({2'b10}));
    @(negedge clk); vec_ready = 1'b1;
    @(negedge clk); #1;

    // upgraded flag
    access(16'hD67E, 1'b1, 8'h01);
    check("R9 flag set", 88'(upgraded), 88'd1);
    rd(6'h3E, rv); check("R9 flag readback", 88'(rv), 88'h01);
    access(16'hD67E, 1'b1, 8'h00);
    check("R10 flag ignores clear", 88'(upgraded), 88'd1);

    // restore back-pressure
    @(negedge clk); ret_ready = 1'b0;
    exp_ret.push_back(SET_B);
    access(16'hD67F, 1'b1, 8'h00);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1;
      check("R7 restore held", {ret_pc, ret_sp, ret_map, ret_a, ret_x, ret_y, ret_z, ret_p}, SET_B);
    end
    access(16'hD640, 1'b0, 8'h00);
    check("R8 trap ignored while waiting", 88'({priv_mode, vec_valid, ret_valid}), 88'({3'b001}));
    @(negedge clk); ret_ready = 1'b1;
    @(negedge clk); #1;

    // CPU reset keeps the flag, power-on clears it
    exp_vec.push_back({1'b1, 16'h8100});
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; #1;
    check("R10 flag survives CPU reset", 88'({upgraded, priv_mode}), 88'({2'b11}));
    exp_vec.push_back({1'b1, 16'h8100});
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; #1;
    check("R10 flag cleared at power-on", 88'(upgraded), 88'd0);

    repeat (3) @(negedge clk);
    check("R2 all vectors seen", 88'(exp_vec.size()), 88'd0);
    check("R6 all restores seen", 88'(exp_ret.size()), 88'd0);
    summary();
    $finish;
  end
endmodule